// File: doc/BRIEF.md
# Programmable Memory Access Port Controller

This block gives a DSP coprocessor a set of six programmable memory access channels. Each channel owns a 32-bit descriptor. The upper half is an access mode and the lower half is a 16-bit word address. There is one bank of descriptors for the write direction and one for the read direction. When the coprocessor writes a data word through a channel, the block decodes that channel's write mode into a target memory: external DRAM, or the 1024-word internal instruction RAM. It then stores the word, either in full or with nibble-selective overwrite. Finally it steps the descriptor address by a programmed stride, or by the cell pattern that alternates +1 and +31.

Descriptors are loaded through a one-shot arming mechanism. The host first arms the block with a 32-bit value. The next access to any valid channel then moves no data. Instead it deposits that value into the channel's write descriptor (for a write access) or its read descriptor (for a read access). The read data path itself lives elsewhere. Here, read accesses only load descriptors or clear status. A registered peek port shows any descriptor, and a registered inspection port shows either memory.

Top module: `pmap_ctrl`

## Requirements
- R1: While the arm flag is set, the next access on a channel below 6 only copies the armed value into descriptor N of the bank chosen by the access direction (write access: write bank; read access: read bank). The flag then drops. A new arm in that same cycle keeps the flag set.
- R2: Every ordinary access (arm flag clear, channel below 6) clears the address-captured flag. A descriptor-loading access leaves it unchanged. `cap_set` sets it, and it has priority in the same cycle.
- R3: A write transfers data only on channel 4, or on any channel while `st_flags` bit 5 or bit 6 is 1. Otherwise the write changes no memory or descriptor and raises no error.
- R4: When (mode & 0x43FF) equals 0x0018, the write stores to DRAM word (address mod 2^DRAM_AW) and the address moves by the programmed stride. The magnitude is set by mode bits 13:11: a value of 0 gives 0, and k = 1..7 gives 2^(k-1). Mode bit 15 set makes the stride negative.
- R5: When (mode & 0xFBFF) equals 0x4018, the write stores to DRAM. The address then grows by 31 if it was odd and by 1 if it was even.
- R6: In either DRAM mode with mode bit 10 set, each 4-bit nibble of the stored word takes the incoming nibble when that nibble is nonzero. Otherwise it keeps the memory's old nibble. With bit 10 clear, the whole word is replaced.
- R7: When (mode & 0x47FF) equals 0x001C, the write stores to instruction RAM word (address bits 9:0), and the address moves by the programmed stride.
- R8: An active write whose mode matches none of the three patterns writes nothing and leaves the descriptor unchanged. `bad_mode` is high for exactly the cycle after it.
- R9: Address stepping wraps modulo 2^16 and never alters the mode half of the descriptor.
- R10: After reset, all descriptors are zero, both flags are low, `bad_mode` is low and `peek_desc` is zero.
- R11: `peek_desc` shows the selected descriptor (bank 0 = write, 1 = read) one clock after selection. `insp_data` shows the selected memory word (0 = DRAM, 1 = instruction RAM) one clock after selection, and it reflects the contents from before any write in that same cycle.
- R12: An access with a channel index of 6 or 7 has no effect at all, including on both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_flags | input | 16 | Coprocessor status word; bits 5 and 6 enable all channels |
| acc_valid | input | 1 | Channel access strobe |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| acc_chan | input | 3 | Channel index |
| acc_data | input | 16 | Write data |
| prog_arm | input | 1 | Arms a descriptor load with `prog_value` |
| prog_value | input | 32 | Descriptor value to deposit |
| cap_set | input | 1 | Sets the address-captured flag |
| peek_bank | input | 1 | Peek bank select (0 write, 1 read) |
| peek_chan | input | 3 | Peek channel select |
| peek_desc | output | 32 | Registered selected descriptor |
| insp_iram | input | 1 | Inspection target (0 DRAM, 1 instruction RAM) |
| insp_addr | input | 10 | Inspection word address |
| insp_data | output | 16 | Registered inspected word |
| prog_pending | output | 1 | Arm flag |
| addr_captured | output | 1 | Address-captured flag |
| bad_mode | output | 1 | One-cycle pulse for an unhandled write mode |

## Verification
Most faults inside this block corrupt the descriptor's address half. Because every later write lands wherever that address points, an error in the stride, sign, cell parity or wrap shows on `peek_desc` one clock after the bad advance. It also sends the following data word to the wrong memory word, where `insp_data` exposes it one clock after the address is inspected. A wrong region decode or a wrong nibble-enable shows as a stale or mixed word on `insp_data` at the next inspection. A mishandled arm flag shows on `prog_pending` in the very next cycle, and later as a descriptor that never loads. A reference model that tracks both banks, both memories and both flags is compared against all outputs on every clock, so a divergence surfaces within a cycle or two of its cause.

// File: rtl/pmap_pkg.sv
package pmap_pkg;

  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_DRAM = 2'd1,
    RGN_IRAM = 2'd2
  } region_e;

  localparam logic [15:0] LIN_MASK  = 16'h43FF;
  localparam logic [15:0] LIN_MATCH = 16'h0018;
  localparam logic [15:0] CEL_MASK  = 16'hFBFF;
  localparam logic [15:0] CEL_MATCH = 16'h4018;
  localparam logic [15:0] IRM_MASK  = 16'h47FF;
  localparam logic [15:0] IRM_MATCH = 16'h001C;

  localparam int OVW_BIT  = 10;
  localparam int NEG_BIT  = 15;
  localparam int STEP_LSB = 11;

  localparam int IRAM_AW = 10;

endpackage

// File: rtl/pmap_mode_decode.sv
module pmap_mode_decode
  import pmap_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [15:0]   mode,
  input  logic [AW-1:0] addr,
  output region_e       region,
  output logic          ovw,
  output logic [AW-1:0] next_addr
);

  localparam logic [AW-1:0] CELL_ODD  = AW'(31);
  localparam logic [AW-1:0] CELL_EVEN = AW'(1);

  logic          is_lin, is_cel, is_irm;
  logic [2:0]    k;
  logic [AW-1:0] mag, stride;

  always_comb begin
    is_lin = (mode & LIN_MASK) == LIN_MATCH;
    is_cel = (mode & CEL_MASK) == CEL_MATCH;
    is_irm = (mode & IRM_MASK) == IRM_MATCH;

    k      = mode[STEP_LSB +: 3];
    mag    = (k == 3'd0) ? '0 : (AW'(1) << (k - 3'd1));
    stride = mode[NEG_BIT] ? (~mag + AW'(1)) : mag;

    if (is_lin || is_cel) region = RGN_DRAM;
    else if (is_irm)      region = RGN_IRAM;
    else                  region = RGN_NONE;

    ovw = (is_lin || is_cel) && mode[OVW_BIT];

    if (is_cel) next_addr = addr + (addr[0] ? CELL_ODD : CELL_EVEN);
    else        next_addr = addr + stride;
  end

endmodule

// File: rtl/pmap_desc_bank.sv
module pmap_desc_bank #(
  parameter int NUM_CH = 6,
  parameter int CH_W   = 3,
  parameter int AW     = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_en,
  input  logic [CH_W-1:0]  ld_ch,
  input  logic [31:0]      ld_val,
  input  logic             adv_en,
  input  logic [CH_W-1:0]  adv_ch,
  input  logic [AW-1:0]    adv_addr,
  input  logic [CH_W-1:0]  sel_ch,
  output logic [31:0]      sel_desc,
  input  logic [CH_W-1:0]  pk_ch,
  output logic [31:0]      pk_desc
);

  logic [31:0] desc_q [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) begin
        desc_q[c] <= '0;
      end else if (ld_en && ld_ch == CH_W'(c)) begin
        desc_q[c] <= ld_val;
      end else if (adv_en && adv_ch == CH_W'(c)) begin
        desc_q[c][AW-1:0] <= adv_addr;
      end
    end
  end

  always_comb begin
    sel_desc = (sel_ch < CH_W'(NUM_CH)) ? desc_q[sel_ch] : '0;
    pk_desc  = (pk_ch  < CH_W'(NUM_CH)) ? desc_q[pk_ch]  : '0;
  end

  // R9: stepping leaves the mode half untouched
  p_mode_kept_r9: assert property (@(posedge clk) disable iff (rst)
    (adv_en && !ld_en && adv_ch < CH_W'(NUM_CH))
      |=> desc_q[$past(adv_ch)][31:16] == $past(desc_q[adv_ch][31:16]));

endmodule

// File: rtl/pmap_nib_ram.sv
module pmap_nib_ram #(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            we,
  input  logic [DW/4-1:0] nib_en,
  input  logic [AW-1:0]   waddr,
  input  logic [DW-1:0]   wdata,
  input  logic [AW-1:0]   raddr,
  output logic [DW-1:0]   rdata
);

  localparam int NLANE = DW / 4;
  localparam int DEPTH = 1 << AW;

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    logic [3:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we && nib_en[l]) mem[waddr] <= wdata[l*4 +: 4];
    end
    always_ff @(posedge clk) begin
      rdata[l*4 +: 4] <= mem[raddr];
    end
  end

endmodule

// File: rtl/pmap_ctrl.sv
module pmap_ctrl
  import pmap_pkg::*;
#(
  parameter int          NUM_CH    = 6,
  parameter int          CH_W      = 3,
  parameter int          OPEN_CH   = 4,
  parameter logic [15:0] ACT_MASK  = 16'h0060,
  parameter int          DRAM_AW   = 10,
  parameter int          DW        = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [15:0]         st_flags,
  input  logic                acc_valid,
  input  logic                acc_write,
  input  logic [CH_W-1:0]     acc_chan,
  input  logic [DW-1:0]       acc_data,
  input  logic                prog_arm,
  input  logic [31:0]         prog_value,
  input  logic                cap_set,
  input  logic                peek_bank,
  input  logic [CH_W-1:0]     peek_chan,
  output logic [31:0]         peek_desc,
  input  logic                insp_iram,
  input  logic [DRAM_AW-1:0]  insp_addr,
  output logic [DW-1:0]       insp_data,
  output logic                prog_pending,
  output logic                addr_captured,
  output logic                bad_mode
);

  localparam int NLANE = DW / 4;
  localparam int AW    = 16;

  logic [31:0] pend_q;
  logic        take, load, ordinary, active, wr_go;
  logic [31:0] wsel, rsel_unused, wpk, rpk;
  region_e     region;
  logic        ovw;
  logic [AW-1:0]    next_addr;
  logic [NLANE-1:0] nib_en;
  logic        dram_we, iram_we, adv_en, err_n;
  logic        insp_iram_q;
  logic [DW-1:0] dram_q, iram_q;

  always_comb begin
    take     = acc_valid && (acc_chan < CH_W'(NUM_CH));
    load     = take && prog_pending;
    ordinary = take && !prog_pending;
    active   = (acc_chan == CH_W'(OPEN_CH)) || ((st_flags & ACT_MASK) != '0);
    wr_go    = ordinary && acc_write && active;
    dram_we  = wr_go && region == RGN_DRAM;
    iram_we  = wr_go && region == RGN_IRAM;
    adv_en   = dram_we || iram_we;
    err_n    = wr_go && region == RGN_NONE;
  end

  pmap_desc_bank #(.NUM_CH(NUM_CH), .CH_W(CH_W), .AW(AW)) u_wbank (
    .clk(clk), .rst(rst),
    .ld_en(load && acc_write), .ld_ch(acc_chan), .ld_val(pend_q),
    .adv_en(adv_en), .adv_ch(acc_chan), .adv_addr(next_addr),
    .sel_ch(acc_chan), .sel_desc(wsel),
    .pk_ch(peek_chan), .pk_desc(wpk)
  );

  pmap_desc_bank #(.NUM_CH(NUM_CH), .CH_W(CH_W), .AW(AW)) u_rbank (
    .clk(clk), .rst(rst),
    .ld_en(load && !acc_write), .ld_ch(acc_chan), .ld_val(pend_q),
    .adv_en(1'b0), .adv_ch(acc_chan), .adv_addr(16'h0000),
    .sel_ch(acc_chan), .sel_desc(rsel_unused),
    .pk_ch(peek_chan), .pk_desc(rpk)
  );

  pmap_mode_decode #(.AW(AW)) u_dec (
    .mode(wsel[31:16]), .addr(wsel[AW-1:0]),
    .region(region), .ovw(ovw), .next_addr(next_addr)
  );

  for (genvar l = 0; l < NLANE; l++) begin : g_nib
    assign nib_en[l] = ovw ? (acc_data[l*4 +: 4] != 4'h0) : 1'b1;
  end

  pmap_nib_ram #(.AW(DRAM_AW), .DW(DW)) u_dram (
    .clk(clk), .we(dram_we), .nib_en(nib_en),
    .waddr(wsel[DRAM_AW-1:0]), .wdata(acc_data),
    .raddr(insp_addr), .rdata(dram_q)
  );

  pmap_nib_ram #(.AW(IRAM_AW), .DW(DW)) u_iram (
    .clk(clk), .we(iram_we), .nib_en({NLANE{1'b1}}),
    .waddr(wsel[IRAM_AW-1:0]), .wdata(acc_data),
    .raddr(insp_addr[IRAM_AW-1:0]), .rdata(iram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q        <= '0;
      prog_pending  <= 1'b0;
      addr_captured <= 1'b0;
      bad_mode      <= 1'b0;
      peek_desc     <= '0;
      insp_iram_q   <= 1'b0;
    end else begin
      if (prog_arm) pend_q <= prog_value;
      if (prog_arm)  prog_pending <= 1'b1;
      else if (load) prog_pending <= 1'b0;
      if (cap_set)       addr_captured <= 1'b1;
      else if (ordinary) addr_captured <= 1'b0;
      bad_mode    <= err_n;
      peek_desc   <= peek_bank ? rpk : wpk;
      insp_iram_q <= insp_iram;
    end
  end

  assign insp_data = insp_iram_q ? iram_q : dram_q;

  // R1: a consuming access drops the arm flag
  p_flag_clears_r1: assert property (@(posedge clk) disable iff (rst)
    (prog_pending && take && !prog_arm) |=> !prog_pending);

  // R2: ordinary access clears the captured flag
  p_cap_clear_r2: assert property (@(posedge clk) disable iff (rst)
    (!prog_pending && take && !cap_set) |=> !addr_captured);

  // R3: disabled channels never touch memory
  p_inactive_r3: assert property (@(posedge clk) disable iff (rst)
    !active |-> !(dram_we || iram_we));

  // R3: at most one memory is written per cycle
  p_one_target_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({dram_we, iram_we}));

  // R8: an error pulse follows an ordinary write access
  p_err_cause_r8: assert property (@(posedge clk) disable iff (rst)
    bad_mode |-> $past(acc_valid && acc_write && !prog_pending));

  // R12: out-of-range channels leave the flags alone
  p_bad_chan_r12: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_chan >= CH_W'(NUM_CH) && !prog_arm && !cap_set)
      |=> $stable(prog_pending) && $stable(addr_captured) && !bad_mode);

endmodule

// File: tb/test_pmap_ctrl.sv
`timescale 1ns/1ps
module test_pmap_ctrl;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] st_flags;
  logic        acc_valid, acc_write;
  logic [2:0]  acc_chan;
  logic [15:0] acc_data;
  logic        prog_arm;
  logic [31:0] prog_value;
  logic        cap_set;
  logic        peek_bank;
  logic [2:0]  peek_chan;
  logic [31:0] peek_desc;
  logic        insp_iram;
  logic [9:0]  insp_addr;
  logic [15:0] insp_data;
  logic        prog_pending, addr_captured, bad_mode;

  always #4 clk = ~clk;

  pmap_ctrl i_pmap_ctrl (
    .clk(clk), .rst(rst), .st_flags(st_flags),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_chan(acc_chan),
    .acc_data(acc_data), .prog_arm(prog_arm), .prog_value(prog_value),
    .cap_set(cap_set), .peek_bank(peek_bank), .peek_chan(peek_chan),
    .peek_desc(peek_desc), .insp_iram(insp_iram), .insp_addr(insp_addr),
    .insp_data(insp_data), .prog_pending(prog_pending),
    .addr_captured(addr_captured), .bad_mode(bad_mode)
  );

  int checks = 0, fails = 0;
  bit finished = 0;
  string phase = "R10 reset";

  // reference model state
  logic [31:0] wd [6];
  logic [31:0] rd [6];
  logic [31:0] pend;
  logic        m_flag, m_cap, e_bad;
  logic [31:0] e_peek;
  logic [15:0] e_insp;
  bit          e_known;
  logic [15:0] dmem [1024];
  bit          dkn  [1024];
  logic [15:0] imem [1024];
  bit          ikn  [1024];

  function automatic logic [15:0] stride(input logic [15:0] m);
    int k = int'(m[13:11]);
    logic [15:0] s = (k == 0) ? 16'd0 : 16'(1 << (k - 1));
    return m[15] ? 16'(-s) : s;
  endfunction

  task automatic model_step();
    logic [15:0] m, a, w;
    bit clr_flag = 0, clr_cap = 0;
    int ch = int'(acc_chan);
    e_peek  = peek_bank ? rd[peek_chan] : wd[peek_chan];
    if (insp_iram) begin e_insp = imem[insp_addr]; e_known = ikn[insp_addr]; end
    else begin e_insp = dmem[insp_addr]; e_known = dkn[insp_addr]; end
    e_bad = 0;
    if (acc_valid && ch < 6) begin
      if (m_flag) begin
        if (acc_write) wd[ch] = pend; else rd[ch] = pend;
        clr_flag = 1;
      end else begin
        clr_cap = 1;
        if (acc_write && (ch == 4 || (st_flags & 16'h0060) != 0)) begin
          m = wd[ch][31:16]; a = wd[ch][15:0];
          if ((m & 16'h43FF) == 16'h0018 || (m & 16'hFBFF) == 16'h4018) begin
            if (m[10]) begin
              w = dmem[a[9:0]];
              for (int n = 0; n < 4; n++)
                if (acc_data[n*4 +: 4] != 0) w[n*4 +: 4] = acc_data[n*4 +: 4];
            end else begin
              w = acc_data; dkn[a[9:0]] = 1;
            end
            dmem[a[9:0]] = w;
            if ((m & 16'hFBFF) == 16'h4018) a = a + (a[0] ? 16'd31 : 16'd1);
            else a = a + stride(m);
          end else if ((m & 16'h47FF) == 16'h001C) begin
            imem[a[9:0]] = acc_data; ikn[a[9:0]] = 1;
            a = a + stride(m);
          end else begin
            e_bad = 1;
          end
          wd[ch] = {m, a};
        end
      end
    end
    if (prog_arm) begin m_flag = 1; pend = prog_value; end
    else if (clr_flag) m_flag = 0;
    if (cap_set) m_cap = 1; else if (clr_cap) m_cap = 0;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 6; i++) begin wd[i] = 0; rd[i] = 0; end
      pend = 0; m_flag = 0; m_cap = 0; e_bad = 0; e_peek = 0; e_known = 0;
    end else begin
      model_step();
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s [%s] actual=%h expected=%h", tag, phase, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    chk("R1 prog_pending", 32'(prog_pending), 32'(m_flag));
    chk("R2 addr_captured", 32'(addr_captured), 32'(m_cap));
    chk("R8 bad_mode", 32'(bad_mode), 32'(e_bad));
    chk("R11 peek_desc", peek_desc, e_peek);
    if (e_known) chk("R11 insp_data", 32'(insp_data), 32'(e_insp));
  endtask

  task automatic idle();
    acc_valid = 0; prog_arm = 0; cap_set = 0;
  endtask

  task automatic load_desc(input bit wr, input int ch, input logic [31:0] v);
    idle(); prog_arm = 1; prog_value = v; step();
    idle(); acc_valid = 1; acc_write = wr; acc_chan = 3'(ch); step();
    idle();
  endtask

  task automatic wr(input int ch, input logic [15:0] d);
    idle(); acc_valid = 1; acc_write = 1; acc_chan = 3'(ch); acc_data = d; step();
    idle();
  endtask

  task automatic peek(input bit bank, input int ch);
    peek_bank = bank; peek_chan = 3'(ch); step(); step();
  endtask

  task automatic look(input bit ir, input int a);
    insp_iram = ir; insp_addr = 10'(a); step(); step();
  endtask

  localparam logic [15:0] MODES [8] = '{16'h0818, 16'h9818, 16'h4018, 16'h0C18,
                                        16'h081C, 16'h0019, 16'h4418, 16'hB01C};

  initial begin
    #(8 * 150000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) begin dkn[i] = 0; ikn[i] = 0; end
    rst = 1; st_flags = 0; acc_write = 0; acc_chan = 0; acc_data = 0;
    prog_value = 0; peek_bank = 0; peek_chan = 0; insp_iram = 0; insp_addr = 0;
    idle();
    repeat (3) @(negedge clk);
    rst = 0;
    phase = "R10 reset";
    for (int c = 0; c < 6; c++) begin peek(0, c); peek(1, c); end

    phase = "R1 R4 linear stride";
    load_desc(1, 4, {16'h0818, 16'h0010});
    peek(0, 4);
    wr(4, 16'h1111); wr(4, 16'h2222); wr(4, 16'h3333);
    look(0, 16'h10); look(0, 16'h11); look(0, 16'h12); peek(0, 4);

    phase = "R9 negative stride wrap";
    load_desc(1, 4, {16'h9818, 16'h0002});
    wr(4, 16'hAAAA); wr(4, 16'hBBBB); peek(0, 4);
    look(0, 16'h002); look(0, 16'h3FE);

    phase = "R5 cell step";
    load_desc(1, 4, {16'h4018, 16'h0005});
    wr(4, 16'h0501); wr(4, 16'h0502); wr(4, 16'h0503); peek(0, 4);
    look(0, 16'h024); look(0, 16'h025);

    phase = "R6 overwrite";
    load_desc(1, 4, {16'h0018, 16'h0100});
    wr(4, 16'h1234);
    load_desc(1, 4, {16'h0418, 16'h0100});
    wr(4, 16'hA0B0); look(0, 16'h100);
    wr(4, 16'h0000); look(0, 16'h100); peek(0, 4);

    phase = "R7 instruction ram";
    load_desc(1, 4, {16'h081C, 16'hFC05});
    wr(4, 16'h7777); wr(4, 16'h8888);
    look(1, 16'h005); look(1, 16'h006); peek(0, 4);

    phase = "R8 unhandled mode";
    load_desc(1, 4, {16'h0019, 16'h0040});
    wr(4, 16'h9999); step(); peek(0, 4);

    phase = "R3 inactive channel";
    load_desc(1, 2, {16'h0818, 16'h0200});
    wr(2, 16'h4242); peek(0, 2);
    st_flags = 16'h0040; wr(2, 16'h4343); peek(0, 2); look(0, 16'h200);
    st_flags = 16'h0020; wr(2, 16'h4444); look(0, 16'h201);
    st_flags = 16'h0000;

    phase = "R1 R2 read bank and capture";
    cap_set = 1; step(); idle();
    load_desc(0, 3, 32'hDEAD_0123); peek(1, 3); peek(0, 3);
    acc_valid = 1; acc_write = 0; acc_chan = 3; step(); idle(); step();

    phase = "R12 bad channel";
    prog_arm = 1; prog_value = 32'h1; cap_set = 1; step(); idle();
    acc_valid = 1; acc_write = 1; acc_chan = 7; step(); idle();
    acc_valid = 1; acc_write = 0; acc_chan = 6; step(); idle(); step();
    acc_valid = 1; acc_write = 1; acc_chan = 5; step(); idle(); peek(0, 5);

    phase = "random mix";
    for (int it = 0; it < 4000; it++) begin
      int r = $urandom_range(0, 99);
      st_flags  = ($urandom_range(0, 3) == 0) ? 16'(1 << $urandom_range(4, 7)) : 16'h0;
      acc_valid = r < 60;
      acc_write = $urandom_range(0, 4) != 0;
      acc_chan  = ($urandom_range(0, 9) == 0) ? 3'($urandom_range(6, 7))
                                               : ($urandom_range(0, 1) ? 3'd4 : 3'($urandom_range(0, 5)));
      acc_data  = 16'($urandom);
      if ($urandom_range(0, 3) == 0) acc_data[7:4] = 4'h0;
      prog_arm  = $urandom_range(0, 6) == 0;
      prog_value = {MODES[$urandom_range(0, 7)], 16'($urandom)};
      cap_set   = $urandom_range(0, 9) == 0;
      peek_bank = 1'($urandom_range(0, 1));
      peek_chan = 3'($urandom_range(0, 5));
      insp_iram = 1'($urandom_range(0, 1));
      insp_addr = 10'($urandom);
      step();
    end
    idle(); step();

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule